// File: doc/BRIEF.md
# Sequential Low-Precision Cosine Transform Engine

This block turns a frame of 128 signed 16-bit audio samples into 128 cosine-transform bins. Samples are written one per cycle whenever the write strobe is high and the block is ready. Only the top five bits of each sample are stored. When the frame is full, the block computes one bin per pass. In each pass, all 128 stored samples are multiplied in parallel by small signed cosine coefficients, and the products are summed into a 17-bit signed result. Each result leaves on a one-cycle output strobe.

The coefficients are never held in memory. For each lane they come from a constant function of the bin index and the lane's sample position. Each multiply is a three-cycle shift-and-add over the four coefficient bits, so no hardware multiplier is needed. The controller has four named states:

- **FILL** accepts samples.
- **MULT** runs the three multiply steps.
- **ACCUM** registers the 128-way sum.
- **EMIT** presents the bin.

The transitions are:

- *frame_full*: FILL to MULT.
- *mul_done*: MULT to ACCUM.
- *sum_taken*: ACCUM to EMIT.
- *next_bin*: EMIT to MULT.
- *frame_done*: EMIT to FILL after bin 127.

Top module: `dctq_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `bin_write` is 0 and `bin_out` is 0.
- R2: A sample is stored on every rising edge where `in_write` and `in_ready` are both 1. The 128th stored sample makes `in_ready` go to 0 in the very next cycle.
- R3: Only bits [15:11] of each sample affect the result, read as a signed 5-bit value. Two frames that differ only in bits [10:0] give identical bins.
- R4: The coefficient for bin k and sample n is round(7·cos(π·(2n+1)·k/256)), rounded half away from zero and limited to −8..7. A frame with sample j set to 0x0800 and every other sample 0 gives bin k equal to that coefficient for sample j.
- R5: Bin k equals the exact sum over n of (bits [15:11] of sample n) × coef(k,n). It is given as a 17-bit two's-complement value.
- R6: Each multiply takes three cycles, so bins come out every 5 cycles. Let E be the edge that stores the 128th sample. Bin k is strobed in the cycle that follows edge E+4+5k.
- R7: `bin_write` is high for exactly one cycle per bin, and `bin_out` holds that bin's value during that cycle.
- R8: Exactly 128 bins are emitted per frame, in ascending index order from 0 to 127.
- R9: While `in_ready` is 0, `in_write` has no effect. The next frame's bins depend only on the samples accepted after `in_ready` returns to 1. `in_ready` is never 1 while `bin_write` is high.
- R10: `in_ready` returns to 1 in the cycle after edge E+640. The whole transform finishes within 1920 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_sample | input | 16 | Signed audio sample |
| in_write | input | 1 | Sample write strobe |
| in_ready | output | 1 | High while samples are being accepted |
| bin_out | output | 17 | Signed transform bin |
| bin_write | output | 1 | One-cycle strobe marking a valid bin |

## Verification
A wrong sample pointer or fill count shows up at the ports immediately:

- A fill count off by one drops `in_ready` one cycle early or late. This is visible in the cycle after the last expected write.
- A bin-index error, a wrong multiply step or a wrong coefficient corrupts the value on `bin_out` at the first affected strobe. Impulse frames tie each value to one coefficient position, so the faulty coefficient can be pinned down.
- A miscounted step or pass moves every later strobe off the 5-cycle grid. It also moves the return of `in_ready` away from 640 cycles after frame-full.
- Samples written while the block is busy and wrongly accepted corrupt the following frame. That corruption appears from its first bin onward.

// File: rtl/dctq_pkg.sv
package dctq_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_MULT  = 2'd1,
        ST_ACCUM = 2'd2,
        ST_EMIT  = 2'd3
    } dctq_state_t;

    // Rounded 7*cos(pi*(2n+1)*k/(2*npts)); angle breakpoints of each
    // magnitude step expressed as fractions (x1e5) of a quarter period.
    function automatic int cos_coef(input int k, input int n, input int npts);
        int m;
        int q;
        int mag;
        bit neg;
        int brk [7];
        brk = '{24207, 42461, 55547, 66667, 76750, 86250, 95445};
        m = ((2 * n + 1) * k) % (4 * npts);
        if (m <= npts) begin
            q = m;            neg = 1'b0;
        end else if (m < 2 * npts) begin
            q = 2 * npts - m; neg = 1'b1;
        end else if (m <= 3 * npts) begin
            q = m - 2 * npts; neg = 1'b1;
        end else begin
            q = 4 * npts - m; neg = 1'b0;
        end
        mag = 7;
        for (int i = 0; i < 7; i++) begin
            if (q * 100000 >= brk[i] * npts) mag = mag - 1;
        end
        return neg ? -mag : mag;
    endfunction

endpackage

// File: rtl/dctq_frame.sv
module dctq_frame #(
    parameter int N      = 128,
    parameter int KEEP_W = 5,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [KEEP_W-1:0] wr_data,
    output logic signed [KEEP_W-1:0] smp [N]
);
    always_ff @(posedge clk) begin
        if (wr_en) smp[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/dctq_lane.sv
module dctq_lane #(
    parameter int X_W = 5,
    parameter int C_W = 4,
    localparam int P_W = X_W + C_W
) (
    input  logic                  clk,
    input  logic                  en,
    input  logic [1:0]            step,
    input  logic signed [X_W-1:0] x,
    input  logic signed [C_W-1:0] c,
    output logic signed [P_W-1:0] prod
);
    logic signed [P_W-1:0] xe, t0, t1, t2, t3;

    assign xe = {{(P_W - X_W){x[X_W-1]}}, x};
    assign t0 = c[0] ? xe          : '0;
    assign t1 = c[1] ? (xe <<< 1)  : '0;
    assign t2 = c[2] ? (xe <<< 2)  : '0;
    assign t3 = c[3] ? (xe <<< 3)  : '0;

    // three add steps: low bits, middle bit, then the negative-weight sign bit
    always_ff @(posedge clk) begin
        if (en) begin
            unique case (step)
                2'd0:    prod <= t0 + t1;
                2'd1:    prod <= prod + t2;
                default: prod <= prod - t3;
            endcase
        end
    end
endmodule

// File: rtl/dctq_sum.sv
module dctq_sum #(
    parameter int N     = 128,
    parameter int P_W   = 9,
    parameter int OUT_W = 17
) (
    input  logic signed [P_W-1:0]   prods [N],
    output logic signed [OUT_W-1:0] total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + OUT_W'(prods[i]);
        end
    end
endmodule

// File: rtl/dctq_engine.sv
module dctq_engine
    import dctq_pkg::*;
#(
    parameter int N      = 128,
    parameter int IN_W   = 16,
    parameter int KEEP_W = 5,
    parameter int C_W    = 4,
    parameter int OUT_W  = 17,
    parameter int BUDGET = 1920,
    localparam int IDX_W = $clog2(N),
    localparam int P_W   = KEEP_W + C_W,
    localparam int BUD_W = $clog2(BUDGET + 2)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IN_W-1:0]         in_sample,
    input  logic                    in_write,
    output logic                    in_ready,
    output logic signed [OUT_W-1:0] bin_out,
    output logic                    bin_write
);
    dctq_state_t state, next;
    logic [IDX_W-1:0]         fill_cnt;
    logic [IDX_W-1:0]         bin_idx;
    logic [1:0]               step;
    logic [BUD_W-1:0]         busy_cyc;
    logic signed [KEEP_W-1:0] smp   [N];
    logic signed [P_W-1:0]    prods [N];
    logic signed [OUT_W-1:0]  total;
    logic                     accept;
    logic                     unused_low_bits;

    assign accept          = (state == ST_FILL) && in_write;
    assign unused_low_bits = ^in_sample[IN_W-KEEP_W-1:0];

    dctq_frame #(.N(N), .KEEP_W(KEEP_W)) u_frame (
        .clk    (clk),
        .wr_en  (accept),
        .wr_idx (fill_cnt),
        .wr_data(in_sample[IN_W-1 -: KEEP_W]),
        .smp    (smp)
    );

    for (genvar n = 0; n < N; n++) begin : g_lane
        logic signed [C_W-1:0] coef;
        assign coef = C_W'(cos_coef(int'(bin_idx), n, N));
        dctq_lane #(.X_W(KEEP_W), .C_W(C_W)) u_lane (
            .clk (clk),
            .en  (state == ST_MULT),
            .step(step),
            .x   (smp[n]),
            .c   (coef),
            .prod(prods[n])
        );
    end

    dctq_sum #(.N(N), .P_W(P_W), .OUT_W(OUT_W)) u_sum (
        .prods(prods),
        .total(total)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_FILL;
        else     state <= next;
    end

    always_comb begin
        next = state;
        unique case (state)
            ST_FILL:  if (in_write && fill_cnt == IDX_W'(N - 1)) next = ST_MULT;
            ST_MULT:  if (step == 2'd2) next = ST_ACCUM;
            ST_ACCUM: next = ST_EMIT;
            ST_EMIT:  next = (bin_idx == IDX_W'(N - 1)) ? ST_FILL : ST_MULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt <= '0;
            bin_idx  <= '0;
            step     <= '0;
            busy_cyc <= '0;
        end else begin
            if (accept) fill_cnt <= (fill_cnt == IDX_W'(N - 1)) ? '0 : fill_cnt + 1'b1;
            if (state == ST_MULT) step <= (step == 2'd2) ? 2'd0 : step + 2'd1;
            if (state == ST_EMIT) bin_idx <= (bin_idx == IDX_W'(N - 1)) ? '0 : bin_idx + 1'b1;
            busy_cyc <= (state == ST_FILL) ? '0 : busy_cyc + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst)                    bin_out <= '0;
        else if (state == ST_ACCUM) bin_out <= total;
    end

    assign in_ready  = (state == ST_FILL);
    assign bin_write = (state == ST_EMIT);

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_write && fill_cnt == IDX_W'(N - 1)) |=> !in_ready);
    // R7
    one_cycle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        bin_write |=> !bin_write);
    // R8
    bin_order_chk: assert property (@(posedge clk) disable iff (rst)
        (bin_write && bin_idx != IDX_W'(N - 1)) |=> (bin_idx == $past(bin_idx) + 1'b1));
    // R8
    first_bin_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> (bin_idx == '0));
    // R9
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        bin_write |-> !in_ready);
    // R10
    budget_chk: assert property (@(posedge clk) disable iff (rst)
        busy_cyc <= BUD_W'(BUDGET));
endmodule

// File: tb/sim_dctq_engine.sv
module sim_dctq_engine;
    localparam int N       = 128;
    localparam int PASS    = 5;
    localparam int LIMIT   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] in_sample = '0;
    logic        in_write = 1'b0;
    logic        in_ready;
    logic [16:0] bin_out;
    logic        bin_write;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    fall_cyc = 0;
    int    rcv = 0;
    bit    prev_ready = 1'b1;
    bit    prev_write = 1'b0;
    string cur_req = "R5";

    logic [15:0] frame_mem [N];
    int exp_bin [N];
    int got_bin [N];
    int saved   [N];

    always #10 clk = ~clk;

    dctq_engine u0 (
        .clk(clk), .rst(rst), .in_sample(in_sample), .in_write(in_write),
        .in_ready(in_ready), .bin_out(bin_out), .bin_write(bin_write)
    );

    always @(posedge clk) cyc++;

    task automatic chk(input longint act, input longint exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_coef(input int k, input int n);
        real v;
        int  r;
        v = 7.0 * $cos(3.14159265358979 * real'((2 * n + 1) * k) / 256.0);
        if (v >= 0.0) r = $rtoi(v + 0.5);
        else          r = -$rtoi(0.5 - v);
        if (r > 7)  r = 7;
        if (r < -8) r = -8;
        return r;
    endfunction

    function automatic int top5(input logic [15:0] s);
        return int'($signed(s[15:11]));
    endfunction

    task automatic compute_expected();
        for (int k = 0; k < N; k++) begin
            int s = 0;
            for (int n = 0; n < N; n++) s += top5(frame_mem[n]) * ref_coef(k, n);
            exp_bin[k] = s;
        end
    endtask

    task automatic send_frame(input string req, input bit gaps);
        int i = 0;
        cur_req = req;
        compute_expected();
        while (i < N) begin
            @(negedge clk);
            if (gaps && ($urandom % 4 == 0)) in_write = 1'b0;
            else begin
                in_write = 1'b1;
                in_sample = frame_mem[i];
                i++;
            end
        end
        @(negedge clk);
        chk(in_ready, 0, "R2");
        // keep writing junk while busy (R9)
        while (!in_ready) begin
            in_write = 1'b1;
            in_sample = 16'($urandom);
            @(negedge clk);
        end
        in_write = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // output monitor
    always @(negedge clk) begin
        if (rst) begin
            prev_ready = 1'b1;
            prev_write = 1'b0;
        end else begin
            if (prev_ready && !in_ready) begin
                fall_cyc = cyc;
                rcv = 0;
            end
            if (bin_write) begin
                if (rcv < N) begin
                    got_bin[rcv] = int'($signed(bin_out));
                    chk(got_bin[rcv], exp_bin[rcv], cur_req);
                    chk(cyc - fall_cyc, 4 + PASS * rcv, "R6");
                end
                chk(in_ready, 0, "R9");
                chk(prev_write, 0, "R7");
                rcv++;
            end
            if (!prev_ready && in_ready) begin
                chk(rcv, N, "R8");
                chk(cyc - fall_cyc, PASS * N, "R10");
                chk((cyc - fall_cyc) <= 1920, 1, "R10");
            end
            prev_ready = in_ready;
            prev_write = bin_write;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(in_ready, 1, "R1");
        chk(bin_write, 0, "R1");
        chk(bin_out, 0, "R1");

        // R5 most negative input everywhere
        for (int n = 0; n < N; n++) frame_mem[n] = 16'h8000;
        send_frame("R5", 1'b0);

        // R5 most positive input everywhere, with gaps
        for (int n = 0; n < N; n++) frame_mem[n] = 16'h7FFF;
        send_frame("R5", 1'b1);

        // R4 impulse at sample 3 with value +1
        for (int n = 0; n < N; n++) frame_mem[n] = (n == 3) ? 16'h0800 : 16'h0000;
        send_frame("R4", 1'b0);

        // R4 impulse at sample 127 with value -1
        for (int n = 0; n < N; n++) frame_mem[n] = (n == 127) ? 16'hF800 : 16'h0000;
        send_frame("R4", 1'b1);

        // R9 random frame after junk writes
        for (int n = 0; n < N; n++) frame_mem[n] = 16'($urandom);
        send_frame("R9", 1'b1);
        for (int k = 0; k < N; k++) saved[k] = got_bin[k];

        // R3 same top bits, new low bits
        for (int n = 0; n < N; n++)
            frame_mem[n] = {frame_mem[n][15:11], 11'($urandom)};
        send_frame("R3", 1'b1);
        for (int k = 0; k < N; k++) chk(got_bin[k], saved[k], "R3");

        finish_run();
    end
endmodule